// File: doc/BRIEF.md
# Vector SHA-2 Sigma Function Unit

The unit applies the SHA-2 sigma transforms to every lane of a 128-bit vector operand in a single clocked step. A mode input chooses the lane layout: four 32-bit words (the SHA-256 functions) or two 64-bit words (the SHA-512 functions). A 5-bit control field makes two choices. Its top bit picks the sigma family for the whole vector: the message-schedule (small) sigma or the compression (capital) sigma. Its low four bits form a mask that picks, lane by lane, which of the two functions of that family is applied.

The operand, mode and control are sampled together when `in_valid` is high. The transformed vector appears on `out_data` one clock later, with `out_valid` marking it. Every lane is computed by the same lane datapath, built once for each width. All rotations and shifts are fixed wiring. The rotator used for this wiring treats an amount of zero as a pass-through, so no shift by the full lane width is ever built.

Top module: `sha_sigma_vec`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_data` to zero on the next rising clock edge.
- R2: `out_valid` equals `in_valid` of the previous cycle. `out_data` takes the result of an accepted operand on that same edge and holds its value in every cycle where `in_valid` was low.
- R3: With `in_mode`=0 the vector is four 32-bit lanes. Lane i occupies bits [127-32i : 96-32i], so lane 0 is the most significant word. Lane i is steered by control bit (3-i).
- R4: In 32-bit mode with control bit 4 = 0, a lane whose steering bit is 0 gives ror7^ror18^shr3, and one whose steering bit is 1 gives ror17^ror19^shr10.
- R5: In 32-bit mode with control bit 4 = 1, a lane whose steering bit is 0 gives ror2^ror13^ror22, and one whose steering bit is 1 gives ror6^ror11^ror25.
- R6: With `in_mode`=1 the vector is two 64-bit lanes. Lane 0 is bits [127:64] and is steered by control bit 3. Lane 1 is bits [63:0] and is steered by control bit 1. Control bits 2 and 0 have no effect on the result in this mode.
- R7: In 64-bit mode with control bit 4 = 0, steering bit 0 gives ror1^ror8^shr7 and steering bit 1 gives ror19^ror61^shr6.
- R8: In 64-bit mode with control bit 4 = 1, steering bit 0 gives ror28^ror34^ror39 and steering bit 1 gives ror14^ror18^ror41.
- R9: Rotations stay inside their own lane, and logical right shifts fill with zeros, so no bit ever moves from one lane into another.
- R10: An all-zero operand yields an all-zero result in every mode and for every control value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand, mode and control are presented this cycle |
| in_mode | input | 1 | Lane layout: 0 = four 32-bit lanes, 1 = two 64-bit lanes |
| in_ctl | input | 5 | Bit 4 selects the sigma family; bits 3..0 are the per-lane variant mask |
| in_data | input | 128 | Vector operand, lane 0 in the most significant bits |
| out_valid | output | 1 | Result on out_data belongs to the operand of the previous cycle |
| out_data | output | 128 | Registered sigma result vector |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector and a 5-bit control field. At these values both layouts exist at once, four 32-bit lanes and two 64-bit lanes. Every one of the eight sigma functions can therefore be reached, and every mask bit can be set alone or combined with the others. The mask values drive neighbouring lanes to different functions in the same operand, which exposes any steering bit wired to the wrong lane. In 64-bit mode, flipping only the ignored mask bits 2 and 0 shows whether they leak into the result. Single-bit operands placed at lane edges show whether any rotation or shift crosses a lane boundary.

// File: rtl/sha_sigma_pkg.sv
package sha_sigma_pkg;

  typedef enum logic {
    MODE_W32 = 1'b0,
    MODE_W64 = 1'b1
  } lane_mode_e;

  // term amounts per (width, family, variant); term C is a shift when family 0
  localparam int W32_S0_A = 7;   localparam int W32_S0_B = 18; localparam int W32_S0_C = 3;
  localparam int W32_S1_A = 17;  localparam int W32_S1_B = 19; localparam int W32_S1_C = 10;
  localparam int W32_C0_A = 2;   localparam int W32_C0_B = 13; localparam int W32_C0_C = 22;
  localparam int W32_C1_A = 6;   localparam int W32_C1_B = 11; localparam int W32_C1_C = 25;

  localparam int W64_S0_A = 1;   localparam int W64_S0_B = 8;  localparam int W64_S0_C = 7;
  localparam int W64_S1_A = 19;  localparam int W64_S1_B = 61; localparam int W64_S1_C = 6;
  localparam int W64_C0_A = 28;  localparam int W64_C0_B = 34; localparam int W64_C0_C = 39;
  localparam int W64_C1_A = 14;  localparam int W64_C1_B = 18; localparam int W64_C1_C = 41;

endpackage

// File: rtl/sig_rotr.sv
module sig_rotr #(
  parameter int W     = 32,
  parameter int AMT   = 0,
  parameter bit SHIFT = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int A = AMT % W;

  generate
    if (A == 0) begin : g_pass
      // zero amount: identity, never a full-width shift
      assign dout = din;
    end else if (SHIFT) begin : g_shr
      assign dout = {{A{1'b0}}, din[W-1:A]};
    end else begin : g_ror
      assign dout = {din[A-1:0], din[W-1:A]};
    end
  endgenerate
endmodule

// File: rtl/sig_fn.sv
module sig_fn #(
  parameter int W      = 32,
  parameter int RA     = 0,
  parameter int RB     = 0,
  parameter int RC     = 0,
  parameter bit C_SHR  = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] t_a, t_b, t_c;

  sig_rotr #(.W(W), .AMT(RA), .SHIFT(1'b0))  u_ta (.din(din), .dout(t_a));
  sig_rotr #(.W(W), .AMT(RB), .SHIFT(1'b0))  u_tb (.din(din), .dout(t_b));
  sig_rotr #(.W(W), .AMT(RC), .SHIFT(C_SHR)) u_tc (.din(din), .dout(t_c));

  assign dout = t_a ^ t_b ^ t_c;
endmodule

// File: rtl/sig_lane.sv
module sig_lane
  import sha_sigma_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         fam,
  input  logic         sel,
  output logic [W-1:0] dout
);
  localparam bit WIDE = (W == 64);
  localparam int S0A = WIDE ? W64_S0_A : W32_S0_A;
  localparam int S0B = WIDE ? W64_S0_B : W32_S0_B;
  localparam int S0C = WIDE ? W64_S0_C : W32_S0_C;
  localparam int S1A = WIDE ? W64_S1_A : W32_S1_A;
  localparam int S1B = WIDE ? W64_S1_B : W32_S1_B;
  localparam int S1C = WIDE ? W64_S1_C : W32_S1_C;
  localparam int C0A = WIDE ? W64_C0_A : W32_C0_A;
  localparam int C0B = WIDE ? W64_C0_B : W32_C0_B;
  localparam int C0C = WIDE ? W64_C0_C : W32_C0_C;
  localparam int C1A = WIDE ? W64_C1_A : W32_C1_A;
  localparam int C1B = WIDE ? W64_C1_B : W32_C1_B;
  localparam int C1C = WIDE ? W64_C1_C : W32_C1_C;

  logic [W-1:0] v_s0, v_s1, v_c0, v_c1;

  sig_fn #(.W(W), .RA(S0A), .RB(S0B), .RC(S0C), .C_SHR(1'b1)) u_s0 (.din(din), .dout(v_s0));
  sig_fn #(.W(W), .RA(S1A), .RB(S1B), .RC(S1C), .C_SHR(1'b1)) u_s1 (.din(din), .dout(v_s1));
  sig_fn #(.W(W), .RA(C0A), .RB(C0B), .RC(C0C), .C_SHR(1'b0)) u_c0 (.din(din), .dout(v_c0));
  sig_fn #(.W(W), .RA(C1A), .RB(C1B), .RC(C1C), .C_SHR(1'b0)) u_c1 (.din(din), .dout(v_c1));

  always_comb begin
    case ({fam, sel})
      2'b00:   dout = v_s0;
      2'b01:   dout = v_s1;
      2'b10:   dout = v_c0;
      default: dout = v_c1;
    endcase
  end
endmodule

// File: rtl/sha_sigma_vec.sv
module sha_sigma_vec
  import sha_sigma_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int CTL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic [CTL_W-1:0] in_ctl,
  input  logic [VEC_W-1:0] in_data,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  localparam int N32     = VEC_W / 32;
  localparam int N64     = VEC_W / 64;
  localparam int MASK_W  = CTL_W - 1;
  localparam int FAM_BIT = CTL_W - 1;

  logic [VEC_W-1:0] res32, res64, res_nxt;

  generate
    for (genvar g = 0; g < N32; g++) begin : g_w32
      sig_lane #(.W(32)) u_lane (
        .din (in_data[VEC_W-1-32*g -: 32]),
        .fam (in_ctl[FAM_BIT]),
        .sel (in_ctl[MASK_W-1-g]),
        .dout(res32[VEC_W-1-32*g -: 32])
      );
    end
    for (genvar g = 0; g < N64; g++) begin : g_w64
      sig_lane #(.W(64)) u_lane (
        .din (in_data[VEC_W-1-64*g -: 64]),
        .fam (in_ctl[FAM_BIT]),
        .sel (in_ctl[MASK_W-1-2*g]),
        .dout(res64[VEC_W-1-64*g -: 64])
      );
    end
  endgenerate

  assign res_nxt = (lane_mode_e'(in_mode) == MODE_W64) ? res64 : res32;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res_nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R2
  AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_data == '0)); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R1
endmodule

// File: tb/sha_sigma_vec_bench.sv
module sha_sigma_vec_bench;
  localparam int VEC_W = 128;
  localparam int CTL_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_mode = 1'b0;
  logic [CTL_W-1:0] in_ctl = '0;
  logic [VEC_W-1:0] in_data = '0;
  logic             out_valid;
  logic [VEC_W-1:0] out_data;

  sha_sigma_vec #(.VEC_W(VEC_W), .CTL_W(CTL_W)) u_sha_sigma_vec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_ctl(in_ctl), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [VEC_W-1:0] exp;
    string            tag;
  } item_t;

  item_t            sb[$];
  int               total = 0;
  int               bad = 0;
  logic             have_last = 1'b0;
  logic [VEC_W-1:0] last_exp = '0;
  logic [63:0]      lfsr = 64'h9E3779B97F4A7C15;

  function automatic logic [31:0] r32(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [63:0] r64(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [31:0] ref32(logic [31:0] x, logic f, logic s);
    if (!f && !s) return r32(x, 7)  ^ r32(x, 18) ^ (x >> 3);
    if (!f &&  s) return r32(x, 17) ^ r32(x, 19) ^ (x >> 10);
    if ( f && !s) return r32(x, 2)  ^ r32(x, 13) ^ r32(x, 22);
    return r32(x, 6) ^ r32(x, 11) ^ r32(x, 25);
  endfunction
  function automatic logic [63:0] ref64(logic [63:0] x, logic f, logic s);
    if (!f && !s) return r64(x, 1)  ^ r64(x, 8)  ^ (x >> 7);
    if (!f &&  s) return r64(x, 19) ^ r64(x, 61) ^ (x >> 6);
    if ( f && !s) return r64(x, 28) ^ r64(x, 34) ^ r64(x, 39);
    return r64(x, 14) ^ r64(x, 18) ^ r64(x, 41);
  endfunction

  function automatic logic [VEC_W-1:0] ref_vec(logic m, logic [4:0] c, logic [VEC_W-1:0] d);
    logic [VEC_W-1:0] r;
    if (!m) begin
      for (int i = 0; i < 4; i++)
        r[127-32*i -: 32] = ref32(d[127-32*i -: 32], c[4], c[3-i]);
    end else begin
      for (int i = 0; i < 2; i++)
        r[127-64*i -: 64] = ref64(d[127-64*i -: 64], c[4], c[3-2*i]);
    end
    return r;
  endfunction

  function automatic logic [63:0] step(logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic chk(logic ok, string tag, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic m, logic [4:0] c, logic [VEC_W-1:0] d, string tag);
    item_t it;
    @(negedge clk);
    it.exp = ref_vec(m, c, d);
    it.tag = tag;
    sb.push_back(it);
    in_valid = 1'b1;
    in_mode  = m;
    in_ctl   = c;
    in_data  = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ~in_data;
      in_ctl   = ~in_ctl;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected out_valid", out_data, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(out_data == it.exp, it.tag, out_data, it.exp);
          have_last = 1'b1;
          last_exp  = it.exp;
        end
      end else if (have_last) begin
        chk(out_data == last_exp, "R2 hold while idle", out_data, last_exp);
      end
    end
  end

  task automatic reset_check();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {127'b0, out_valid}, '0);
    chk(out_data == '0, "R1 out_data after reset", out_data, '0);
    have_last = 1'b0;
    in_valid = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    logic [VEC_W-1:0] d;
    reset_check();

    // R4 / R5: 32-bit families, uniform masks
    d = 128'h0123456789ABCDEF_FEDCBA9876543210;
    send(1'b0, 5'h00, d, "R4 w32 small mask0");
    send(1'b0, 5'h0F, d, "R4 w32 small mask1");
    send(1'b0, 5'h10, d, "R5 w32 capital mask0");
    send(1'b0, 5'h1F, d, "R5 w32 capital mask1");
    idle(2);
    // R3: per-lane steering, one mask bit at a time
    for (int b = 0; b < 4; b++) begin
      send(1'b0, 5'(1 << b), d, "R3 w32 single mask bit small");
      send(1'b0, 5'h10 | 5'(1 << b), d, "R3 w32 single mask bit capital");
    end
    send(1'b0, 5'h0A, 128'h80000000_00000001_80000000_00000001, "R3 w32 alternating mask");
    send(1'b0, 5'h15, 128'h00000001_80000000_00000001_80000000, "R3 w32 capital alt mask");
    idle(1);
    // R7 / R8: 64-bit families
    send(1'b1, 5'h00, d, "R7 w64 small mask0");
    send(1'b1, 5'h0A, d, "R7 w64 small mask1");
    send(1'b1, 5'h10, d, "R8 w64 capital mask0");
    send(1'b1, 5'h1A, d, "R8 w64 capital mask1");
    send(1'b1, 5'h08, d, "R6 w64 lane0 bit3 only");
    send(1'b1, 5'h02, d, "R6 w64 lane1 bit1 only");
    // R6: ignored bits 2 and 0 must not change the result
    send(1'b1, 5'h05, d, "R6 w64 ignored bits set small");
    send(1'b1, 5'h15, d, "R6 w64 ignored bits set capital");
    send(1'b1, 5'h0F, d, "R6 w64 all bits small");
    send(1'b1, 5'h1F, d, "R6 w64 all bits capital");
    idle(3);
    // R9: single bits at lane boundaries
    for (int p = 0; p < 128; p += 16) begin
      send(1'b0, 5'(p % 32), 128'b1 << p, "R9 w32 lane edge bit");
      send(1'b1, 5'(p % 32), 128'b1 << p, "R9 w64 lane edge bit");
    end
    send(1'b0, 5'h00, {4{32'h80000001}}, "R9 w32 edge bits both ends");
    send(1'b1, 5'h1A, {2{64'h8000000000000001}}, "R9 w64 edge bits both ends");
    // R10: zero operand
    for (int c = 0; c < 32; c += 5) begin
      send(1'b0, 5'(c), '0, "R10 zero operand w32");
      send(1'b1, 5'(c), '0, "R10 zero operand w64");
    end
    idle(2);
    // mixed pseudo-random traffic with gaps
    for (int k = 0; k < 200; k++) begin
      logic [63:0] a;
      lfsr = step(lfsr); a = lfsr;
      lfsr = step(lfsr);
      send(lfsr[0], lfsr[12:8], {a, lfsr}, lfsr[0] ? "R7 R8 w64 random" : "R4 R5 w32 random");
      if (lfsr[20]) idle(1);
    end
    idle(3);
    reset_check();
    send(1'b0, 5'h1F, {4{32'hDEADBEEF}}, "R5 after second reset");
    idle(3);
    chk(sb.size() == 0, "R2 all results delivered", 128'(sb.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule